// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces the periodic CAS-before-RAS refresh of a DRAM controller. Software programs a single write-only control word over a simple peripheral bus. The word holds a run bit and two divider fields. The bus clock feeds two dividers in series. The first is a prescaler that produces strobes at twice the reference rate, where the reference rate is the bus clock divided by the prescale field. The second counts rate-field-plus-one of those strobes and then raises one refresh request.

The request is a level toward the DRAM command sequencer. It stays high until the sequencer returns a one-cycle acknowledge. Requests that arrive while an earlier one is still outstanding are counted, so none is lost unless more than seven build up. The block only asks for refreshes: row addressing and RAS/CAS timing belong to the sequencer.

The block also drives a self-refresh enable. The controller uses it while it sits in power-down, and the run bit gates it. The control word is cleared only by the power-on reset. A separate warm-clear input restarts the dividers and drops pending work but leaves the programmed word untouched.

Top module: `rfsh_req_timer`

## Requirements
- R1: A write updates the control word only when `bus_sel`, `bus_we` and a zero `bus_addr` are all high/zero together in one cycle. Writes to any other offset, and cycles without select, leave it unchanged. No read path exists.
- R2: In the control word, bits 15:8 are the prescale field P, bit 7 is the run bit, and bits 6:0 are the rate field D.
- R3: Only `por_n` low clears the control word, and it clears it to 16'h0000. `warm_clr` high clears the divider state and the pending count, but does not alter the control word.
- R4: With run set and P and D nonzero, requests occur on average once every max(P,2)·(D+1)/2 bus clocks, with at most one prescaler strobe per clock.
- R5: When P is zero or D is zero, no refresh request is ever raised.
- R6: When the run bit is 0, no request is raised. A write that clears the run bit also drops all pending requests, and `rfsh_req` is low from the following cycle.
- R7: `rfsh_req` is high whenever at least one request is pending. Each cycle with `rfsh_ack` high while a request is pending retires exactly one request. When a new request arrives in the same cycle as an acknowledge, the pending count is left unchanged.
- R8: The pending count saturates at 7. Requests that arrive beyond that are dropped.
- R9: `self_rfsh` is high exactly when the run bit is 1 and `pdown` is high.
- R10: Every accepted write restarts both divider stages from zero. Rewriting the word more often than one request period therefore yields no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_clr | input | 1 | Synchronous clear of dividers and pending count |
| bus_sel | input | 1 | Peripheral select |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 16 | Write data |
| pdown | input | 1 | Controller is in power-down |
| rfsh_ack | input | 1 | Sequencer acknowledge, one pulse per refresh |
| rfsh_req | output | 1 | Refresh request, held while any is pending |
| self_rfsh | output | 1 | Self-refresh enable |

## Verification
The hardest state to reach is a full pending count. It appears only when the sequencer withholds acknowledges across many request periods. It must then be drained with no new arrivals, so that exactly seven acknowledges are seen. The stimulus programs the fastest rate and holds acknowledge low for well over seven periods. It then rewrites the word with a zero prescale field while keeping the run bit set, which stops arrivals without flushing the count. Finally it counts the acknowledges that bring the request low. Randomly chosen field pairs check the average rate against the formula, and directed runs cover the zero fields, repeated rewrites and both reset kinds.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int PRE_W  = 8;
    localparam int RATE_W = 7;
    localparam int REG_W  = PRE_W + 1 + RATE_W;

    // Field order follows bit position: prescale 15:8, run 7, rate 6:0
    typedef struct packed {
        logic [PRE_W-1:0]  pre_div;
        logic              run;
        logic [RATE_W-1:0] rate_div;
    } cfg_t;
endpackage

// File: rtl/rfsh_prescale.sv
module rfsh_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic [W-1:0] divisor,
    output logic         strobe
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         stb;
    } st_t;

    st_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.acc} + (W+1)'(2);
        st_d = st_q;
        st_d.stb = 1'b0;
        if (clr || divisor == '0) begin
            st_d.acc = '0;
        end else if (sum >= {1'b0, divisor}) begin
            st_d.stb = 1'b1;
            // divisor of 1 would let the residue grow: cap at one strobe per clock
            st_d.acc = (divisor == W'(1)) ? '0 : W'(sum - {1'b0, divisor});
        end else begin
            st_d.acc = W'(sum);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.stb;
endmodule

// File: rtl/rfsh_rate_div.sv
module rfsh_rate_div #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic         strobe,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (strobe && limit != '0) begin
            if (cnt_q >= limit) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic         arrive,
    input  logic         ack,
    output logic [W-1:0] count,
    output logic         req
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;
    logic         take;

    always_comb begin
        take  = ack && (cnt_q != '0);
        cnt_d = cnt_q;
        if (clr)                  cnt_d = '0;
        else if (arrive && !take) cnt_d = (cnt_q == MAXV) ? MAXV : cnt_q + W'(1);
        else if (take && !arrive) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign req   = (cnt_q != '0);
endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer
    import rfsh_pkg::*;
#(
    parameter int AW     = 4,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_clr,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              pdown,
    input  logic              rfsh_ack,
    output logic              rfsh_req,
    output logic              self_rfsh
);
    cfg_t              cfg_d, cfg_q;
    logic              cfg_wr;
    logic              div_clr;
    logic              pend_clr;
    logic              pre_stb;
    logic              rate_tick;
    logic [PEND_W-1:0] pend_cnt;

    always_comb begin
        cfg_wr   = bus_sel && bus_we && (bus_addr == '0);
        cfg_d    = cfg_wr ? cfg_t'(bus_wdata) : cfg_q;
        div_clr  = cfg_wr || warm_clr || !cfg_q.run;
        pend_clr = warm_clr || !cfg_q.run || (cfg_wr && !cfg_d.run);
    end

    // Control word: power-on reset is its only clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    rfsh_prescale #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (div_clr),
        .divisor (cfg_q.pre_div),
        .strobe  (pre_stb)
    );

    rfsh_rate_div #(.W(RATE_W)) u_rate (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (div_clr),
        .strobe (pre_stb),
        .limit  (cfg_q.rate_div),
        .tick   (rate_tick)
    );

    rfsh_pend #(.W(PEND_W)) u_pend (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (pend_clr),
        .arrive (rate_tick),
        .ack    (rfsh_ack),
        .count  (pend_cnt),
        .req    (rfsh_req)
    );

    assign self_rfsh = cfg_q.run && pdown;
endmodule

// File: rtl/rfsh_req_timer_chk.sv
module rfsh_req_timer_chk
    import rfsh_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic              warm_clr,
    input logic              cfg_wr,
    input cfg_t              cfg_q,
    input logic              rate_tick,
    input logic              rfsh_ack,
    input logic              rfsh_req,
    input logic              self_rfsh,
    input logic              pdown,
    input logic [PEND_W-1:0] pend_cnt
);
    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    // R5
    zero_field_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_q.pre_div == '0 || cfg_q.rate_div == '0) |-> !rate_tick);

    // R6
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_q.run |-> !rfsh_req);

    // R3
    warm_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm_clr && !cfg_wr) |=> $stable(cfg_q));

    // R3
    warm_drops_pend_chk: assert property (@(posedge clk) disable iff (!por_n)
        warm_clr |=> !rfsh_req);

    // R7
    ack_retires_one_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rfsh_req && rfsh_ack && !rate_tick && cfg_q.run && !warm_clr && !cfg_wr)
        |=> pend_cnt == $past(pend_cnt) - PEND_W'(1));

    // R8
    pend_saturate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pend_cnt == MAXV && rate_tick && !rfsh_ack && !warm_clr && !cfg_wr)
        |=> pend_cnt == MAXV);

    // R9
    self_needs_pdown_chk: assert property (@(posedge clk) disable iff (!por_n)
        self_rfsh |-> (pdown && cfg_q.run));
endmodule

bind rfsh_req_timer rfsh_req_timer_chk #(.PEND_W(PEND_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .warm_clr  (warm_clr),
    .cfg_wr    (cfg_wr),
    .cfg_q     (cfg_q),
    .rate_tick (rate_tick),
    .rfsh_ack  (rfsh_ack),
    .rfsh_req  (rfsh_req),
    .self_rfsh (self_rfsh),
    .pdown     (pdown),
    .pend_cnt  (pend_cnt)
);

// File: tb/rfsh_req_timer_tb.sv
module rfsh_req_timer_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_clr = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        pdown = 1'b0;
    logic        rfsh_ack = 1'b0;
    logic        rfsh_req;
    logic        self_rfsh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rfsh_req_timer u_dut (
        .clk(clk), .por_n(por_n), .warm_clr(warm_clr),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pdown(pdown), .rfsh_ack(rfsh_ack),
        .rfsh_req(rfsh_req), .self_rfsh(self_rfsh)
    );

    function automatic logic [15:0] word(input int p, input bit run, input int d);
        return {p[7:0], run, d[6:0]};
    endfunction

    function automatic int exp_reqs(input int cyc, input int p, input int d);
        int pe = (p < 2) ? 2 : p;
        if (p == 0 || d == 0) return 0;
        return (2 * cyc) / (pe * (d + 1));
    endfunction

    task automatic chk(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] v, input bit sel);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Runs n cycles, acknowledging every pending request, returns acknowledge count
    task automatic run_ack(input int n, output int acks);
        acks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rfsh_ack = rfsh_req;
            if (rfsh_req) acks++;
        end
        @(negedge clk);
        rfsh_ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int unsigned seed;
        seed = $urandom(32'h0000_5eed);
        repeat (3) @(negedge clk);
        // R3 reset state
        chk("R3 reset req", int'(rfsh_req), 0, 0);
        pdown = 1'b1;
        #1 chk("R3 reset self", int'(self_rfsh), 0, 0);
        por_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 self refresh follows run and pdown
        bus_wr(4'h0, word(0, 1'b1, 0), 1'b1);
        chk("R9 self on", int'(self_rfsh), 1, 0);
        pdown = 1'b0;
        #1 chk("R9 self off with pdown low", int'(self_rfsh), 0, 0);
        pdown = 1'b1;

        // R5 zero fields
        bus_wr(4'h0, word(0, 1'b1, 5), 1'b1);
        run_ack(1500, n); chk("R5 P zero", n, 0, 0);
        bus_wr(4'h0, word(6, 1'b1, 0), 1'b1);
        run_ack(1500, n); chk("R5 D zero", n, 0, 0);

        // R6 run bit cleared
        bus_wr(4'h0, word(4, 1'b0, 3), 1'b1);
        chk("R6 self with run low", int'(self_rfsh), 0, 0);
        run_ack(1000, n); chk("R6 no req when stopped", n, 0, 0);

        // R2/R4 directed rate: P=10, D=4 -> 25 cycles
        bus_wr(4'h0, word(10, 1'b1, 4), 1'b1);
        run_ack(2500, n); chk("R2 R4 rate P10 D4", n, exp_reqs(2500, 10, 4), 2);
        // R4 prescale of 1 capped at one strobe per clock
        bus_wr(4'h0, word(1, 1'b1, 3), 1'b1);
        run_ack(400, n); chk("R4 P one", n, exp_reqs(400, 1, 3), 2);

        // R1 ignored writes: other offset and no select
        bus_wr(4'h0, word(8, 1'b1, 9), 1'b1);
        bus_wr(4'h4, 16'h0000, 1'b1);
        bus_wr(4'h0, 16'h0000, 1'b0);
        run_ack(2000, n); chk("R1 ignored writes keep rate", n, exp_reqs(2000, 8, 9), 2);

        // R10 rewriting faster than the period yields nothing (period 100)
        n = 0;
        for (int k = 0; k < 20; k++) begin
            int a;
            bus_wr(4'h0, word(10, 1'b1, 19), 1'b1);
            run_ack(55, a);
            n += a;
        end
        chk("R10 rewrite restarts dividers", n, 0, 0);

        // R8 saturation, then drain without arrivals
        bus_wr(4'h0, word(2, 1'b1, 1), 1'b1);
        rfsh_ack = 1'b0;
        repeat (60) @(negedge clk);
        bus_wr(4'h0, word(0, 1'b1, 1), 1'b1);
        run_ack(30, n); chk("R8 pending saturates at 7", n, 7, 0);
        chk("R7 req low once drained", int'(rfsh_req), 0, 0);

        // R7 request held without ack
        bus_wr(4'h0, word(2, 1'b1, 2), 1'b1);
        repeat (20) @(negedge clk);
        chk("R7 req held", int'(rfsh_req), 1, 0);
        // R6 clearing run drops pending
        bus_wr(4'h0, word(2, 1'b0, 2), 1'b1);
        chk("R6 pending dropped", int'(rfsh_req), 0, 0);

        // R3 warm clear: pending dropped, word kept
        bus_wr(4'h0, word(2, 1'b1, 2), 1'b1);
        repeat (20) @(negedge clk);
        warm_clr = 1'b1;
        @(negedge clk);
        warm_clr = 1'b0;
        chk("R3 warm clear drops req", int'(rfsh_req), 0, 0);
        chk("R3 warm clear keeps word", int'(self_rfsh), 1, 0);
        run_ack(300, n); chk("R3 rate after warm clear", n, exp_reqs(300, 2, 2), 2);

        // R4 random field pairs
        for (int t = 0; t < 12; t++) begin
            int p, d;
            p = 2 + int'($urandom_range(38));
            d = 1 + int'($urandom_range(19));
            bus_wr(4'h0, word(p, 1'b0, d), 1'b1);
            bus_wr(4'h0, word(p, 1'b1, d), 1'b1);
            run_ack(3000, n);
            chk($sformatf("R4 random P%0d D%0d", p, d), n, exp_reqs(3000, p, d), 2);
        end

        // R3 power-on reset clears the word
        bus_wr(4'h0, word(4, 1'b1, 2), 1'b1);
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        chk("R3 por clears self", int'(self_rfsh), 0, 0);
        run_ack(500, n); chk("R3 por no req", n, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule